// File: doc/BRIEF.md
# CSI-2 Packet Parser

This block sits behind the lane-merging stage of a camera receiver. It takes one byte per clock, plus a strobe that marks the first byte of a burst and a strobe that marks the end of the burst, and splits the low-level protocol stream into packets. It reads the four header bytes and reports the channel number, the data type, the 16-bit field and the header check byte. It then decides from the data type whether the packet is short, long or reserved.

Short packets come out as a single event carrying their 16-bit value. Separate strobes flag frame and line boundaries. For long packets the block passes exactly the announced number of payload bytes downstream, each tagged with channel and type. It then takes the two-byte footer and compares it with a CRC-16 computed over the payload. Reserved types, bursts that end too early and footer mismatches each raise their own single-cycle error flag. All outputs are registered, so every result appears one cycle after the byte or strobe that caused it.

Top module: `csi2_pkt_parser`

## Requirements
- R1: While no packet is open (after reset, after a completed short packet, or after a long packet's footer), bytes with `in_valid` but without `in_sot` produce no header, event, payload or error output until the next `in_sot`.
- R2: A byte with `in_sot` and `in_valid` is header byte 0; the fourth header byte raises `hdr_valid` for one cycle, in the cycle after it is accepted, with `hdr_vc` = byte0[7:6], `hdr_dt` = byte0[5:0], `hdr_field` = {byte2, byte1} (low byte first) and `hdr_ecc` = byte3.
- R3: Data types 0x00 to 0x0F are short: `sp_valid` pulses together with `hdr_valid`, carrying `sp_vc`, `sp_dt` and `sp_data` = the header field. No payload or CRC check follows, and any later bytes up to `in_eot` are dropped.
- R4: Short type 0x00 pulses `evt_frame_start`, 0x01 `evt_frame_end`, 0x02 `evt_line_start` and 0x03 `evt_line_end`, each in the same cycle as `sp_valid`. Other short types (0x04 to 0x0F) raise no boundary strobe.
- R5: Data types 0x10 to 0x37 are long: exactly field-many payload bytes appear on `pl_byte` with `pl_valid`, each one cycle after acceptance, tagged with `pl_vc` and `pl_dt`. `pl_last` marks the final one. Bytes after the footer are dropped.
- R6: The payload down-counter stops at zero. A long packet whose field is 0 emits no payload, and its next two bytes are taken as the footer.
- R7: The footer is sent low byte first and compared with the CRC-16 over the payload bytes only. The CRC uses polynomial x^16+x^12+x^5+1, seed 0xFFFF, bits taken least significant first (reflected constant 0x8408), and no final inversion. A mismatch pulses `crc_error` for exactly one cycle, one cycle after the second footer byte; a match leaves it low.
- R8: Data types 0x38 to 0x3F pulse `rsvd_error` together with `hdr_valid`. No short event and no payload follow, and the rest of the burst is dropped.
- R9: `in_eot` while the header is incomplete, or while a long packet's payload or footer is incomplete, pulses `trunc_error` one cycle later. `in_eot` after a complete packet or while idle raises none.
- R10: During reset and in the first cycle after it, every valid, event and error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Merged lane byte |
| in_sot | input | 1 | Marks the first byte of a burst (with `in_valid`) |
| in_eot | input | 1 | End-of-burst strobe; the byte in that cycle is ignored |
| hdr_valid | output | 1 | Header decoded |
| hdr_vc | output | 2 | Virtual channel of the header |
| hdr_dt | output | 6 | Data type of the header |
| hdr_field | output | 16 | Word count or short-packet value |
| hdr_ecc | output | 8 | Header check byte as received |
| sp_valid | output | 1 | Short packet event |
| sp_vc | output | 2 | Channel of the short packet |
| sp_dt | output | 6 | Type of the short packet |
| sp_data | output | 16 | Short packet value |
| evt_frame_start | output | 1 | Frame start strobe |
| evt_frame_end | output | 1 | Frame end strobe |
| evt_line_start | output | 1 | Line start strobe |
| evt_line_end | output | 1 | Line end strobe |
| pl_valid | output | 1 | Payload byte valid |
| pl_byte | output | 8 | Payload byte |
| pl_vc | output | 2 | Channel tag of the payload |
| pl_dt | output | 6 | Type tag of the payload |
| pl_last | output | 1 | Final payload byte of the packet |
| crc_error | output | 1 | Footer did not match the payload CRC |
| rsvd_error | output | 1 | Reserved data type received |
| trunc_error | output | 1 | Burst ended before the packet was complete |

## Verification
On every cycle the assertions hold the structural rules. The payload counter never sits at zero while payload is expected. Boundary strobes are at most one-hot and only come with a short event. Payload never shares a cycle with a header or short event. A reserved-type error always coincides with its header. A CRC error never lasts two cycles. Whether the data is right cannot be seen that way, so the directed scenarios supply it. They show the header field byte order, the exact payload byte values and count, the CRC comparison result for good and corrupted footers, an empty long packet, dropped bytes outside an open packet, and which endings count as truncation.

// File: rtl/csi2_pkt_pkg.sv
package csi2_pkt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CRC_W  = 16;

    // data type ranges (upper bounds, inclusive)
    localparam logic [5:0] DT_SYNC_MAX  = 6'h07;
    localparam logic [5:0] DT_SHORT_MAX = 6'h0F;
    localparam logic [5:0] DT_LONG_MAX  = 6'h37;

    localparam logic [CRC_W-1:0] CRC_SEED      = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [1:0] {
        CLS_SYNC,
        CLS_GENERIC,
        CLS_LONG,
        CLS_RSVD
    } pkt_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAYLOAD,
        ST_FOOT,
        ST_DRAIN
    } parse_state_e;

endpackage

// File: rtl/csi2_dt_classify.sv
module csi2_dt_classify
    import csi2_pkt_pkg::*;
#(
    parameter int unsigned DT_W = 6
) (
    input  logic [DT_W-1:0] dt,
    output pkt_class_e      cls
);
    localparam logic [DT_W-1:0] SYNC_MAX  = DT_W'(DT_SYNC_MAX);
    localparam logic [DT_W-1:0] SHORT_MAX = DT_W'(DT_SHORT_MAX);
    localparam logic [DT_W-1:0] LONG_MAX  = DT_W'(DT_LONG_MAX);

    always_comb begin
        if (dt <= SYNC_MAX)       cls = CLS_SYNC;
        else if (dt <= SHORT_MAX) cls = CLS_GENERIC;
        else if (dt <= LONG_MAX)  cls = CLS_LONG;
        else                      cls = CLS_RSVD;
    end
endmodule

// File: rtl/csi2_crc16_step.sv
module csi2_crc16_step
    import csi2_pkt_pkg::*;
#(
    parameter int unsigned         DATA_W = 8,
    parameter logic [CRC_W-1:0]    POLY   = CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] chain [0:DATA_W];

    assign chain[0] = crc_in;

    // one shift stage per data bit, least significant bit first
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb          = chain[i][0] ^ data[i];
        assign chain[i+1]  = (chain[i] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/csi2_sync_decode.sv
module csi2_sync_decode #(
    parameter int unsigned DT_W  = 6,
    parameter int unsigned N_EVT = 4
) (
    input  logic             en,
    input  logic [DT_W-1:0]  dt,
    output logic [N_EVT-1:0] evt
);
    // event i fires for synchronisation code i
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        assign evt[i] = en && (dt == DT_W'(i));
    end
endmodule

// File: rtl/csi2_pkt_parser.sv
module csi2_pkt_parser
    import csi2_pkt_pkg::*;
#(
    parameter int unsigned WC_W = 16,
    parameter int unsigned VC_W = 2,
    parameter int unsigned DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic            in_sot,
    input  logic            in_eot,
    output logic            hdr_valid,
    output logic [VC_W-1:0] hdr_vc,
    output logic [DT_W-1:0] hdr_dt,
    output logic [WC_W-1:0] hdr_field,
    output logic [7:0]      hdr_ecc,
    output logic            sp_valid,
    output logic [VC_W-1:0] sp_vc,
    output logic [DT_W-1:0] sp_dt,
    output logic [WC_W-1:0] sp_data,
    output logic            evt_frame_start,
    output logic            evt_frame_end,
    output logic            evt_line_start,
    output logic            evt_line_end,
    output logic            pl_valid,
    output logic [7:0]      pl_byte,
    output logic [VC_W-1:0] pl_vc,
    output logic [DT_W-1:0] pl_dt,
    output logic            pl_last,
    output logic            crc_error,
    output logic            rsvd_error,
    output logic            trunc_error
);
    localparam int unsigned DID_W   = VC_W + DT_W;
    localparam int unsigned N_EVT   = 4;
    localparam int unsigned HBYTE_W = 2;
    localparam logic [HBYTE_W-1:0] HDR_LAST = HBYTE_W'(3);

    typedef struct packed {
        parse_state_e         st;
        logic [HBYTE_W-1:0]   hcnt;
        logic [DID_W-1:0]     did;
        logic [WC_W-1:0]      field;
        logic [7:0]           ecc;
        logic [WC_W-1:0]      remain;
        logic [CRC_W-1:0]     crc;
        logic [7:0]           foot_lo;
        logic                 foot_half;
        logic                 hdr_valid;
        logic                 sp_valid;
        logic [N_EVT-1:0]     evt;
        logic                 pl_valid;
        logic [7:0]           pl_byte;
        logic                 pl_last;
        logic                 crc_error;
        logic                 rsvd_error;
        logic                 trunc_error;
    } parse_t;

    parse_t q, d;

    pkt_class_e       cls;
    logic [N_EVT-1:0] sync_evt;
    logic [CRC_W-1:0] crc_nx;

    csi2_dt_classify #(.DT_W(DT_W)) u_cls (
        .dt  (q.did[DT_W-1:0]),
        .cls (cls)
    );

    csi2_sync_decode #(.DT_W(DT_W), .N_EVT(N_EVT)) u_sync (
        .en  (cls == CLS_SYNC),
        .dt  (q.did[DT_W-1:0]),
        .evt (sync_evt)
    );

    csi2_crc16_step #(.DATA_W(BYTE_W)) u_crc (
        .crc_in  (q.crc),
        .data    (in_byte),
        .crc_out (crc_nx)
    );

    always_comb begin
        d             = q;
        d.hdr_valid   = 1'b0;
        d.sp_valid    = 1'b0;
        d.evt         = '0;
        d.pl_valid    = 1'b0;
        d.pl_last     = 1'b0;
        d.crc_error   = 1'b0;
        d.rsvd_error  = 1'b0;
        d.trunc_error = 1'b0;

        if (in_sot && in_valid) begin
            d.st   = ST_HDR;
            d.did  = in_byte;
            d.hcnt = HBYTE_W'(1);
        end else if (in_eot) begin
            if (q.st == ST_HDR || q.st == ST_PAYLOAD || q.st == ST_FOOT)
                d.trunc_error = 1'b1;
            d.st = ST_IDLE;
        end else if (in_valid) begin
            unique case (q.st)
                ST_HDR: begin
                    d.hcnt = q.hcnt + HBYTE_W'(1);
                    if (q.hcnt == HBYTE_W'(1)) begin
                        d.field[7:0] = in_byte;
                    end else if (q.hcnt == HBYTE_W'(2)) begin
                        d.field[WC_W-1:8] = in_byte[WC_W-9:0];
                    end else if (q.hcnt == HDR_LAST) begin
                        d.ecc       = in_byte;
                        d.hdr_valid = 1'b1;
                        unique case (cls)
                            CLS_SYNC, CLS_GENERIC: begin
                                d.sp_valid = 1'b1;
                                d.evt      = sync_evt;
                                d.st       = ST_DRAIN;
                            end
                            CLS_LONG: begin
                                d.remain    = q.field;
                                d.crc       = CRC_SEED;
                                d.foot_half = 1'b0;
                                d.st        = (q.field == '0) ? ST_FOOT : ST_PAYLOAD;
                            end
                            default: begin
                                d.rsvd_error = 1'b1;
                                d.st         = ST_DRAIN;
                            end
                        endcase
                    end
                end
                ST_PAYLOAD: begin
                    d.pl_valid = 1'b1;
                    d.pl_byte  = in_byte;
                    d.crc      = crc_nx;
                    d.remain   = q.remain - WC_W'(1);
                    if (q.remain == WC_W'(1)) begin
                        d.pl_last   = 1'b1;
                        d.foot_half = 1'b0;
                        d.st        = ST_FOOT;
                    end
                end
                ST_FOOT: begin
                    if (!q.foot_half) begin
                        d.foot_lo   = in_byte;
                        d.foot_half = 1'b1;
                    end else begin
                        d.crc_error = ({in_byte, q.foot_lo} != q.crc);
                        d.st        = ST_DRAIN;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hdr_valid       = q.hdr_valid;
    assign hdr_vc          = q.did[DID_W-1:DT_W];
    assign hdr_dt          = q.did[DT_W-1:0];
    assign hdr_field       = q.field;
    assign hdr_ecc         = q.ecc;
    assign sp_valid        = q.sp_valid;
    assign sp_vc           = q.did[DID_W-1:DT_W];
    assign sp_dt           = q.did[DT_W-1:0];
    assign sp_data         = q.field;
    assign evt_frame_start = q.evt[0];
    assign evt_frame_end   = q.evt[1];
    assign evt_line_start  = q.evt[2];
    assign evt_line_end    = q.evt[3];
    assign pl_valid        = q.pl_valid;
    assign pl_byte         = q.pl_byte;
    assign pl_vc           = q.did[DID_W-1:DT_W];
    assign pl_dt           = q.did[DT_W-1:0];
    assign pl_last         = q.pl_last;
    assign crc_error       = q.crc_error;
    assign rsvd_error      = q.rsvd_error;
    assign trunc_error     = q.trunc_error;

    // payload counter never idles at zero while payload is still expected
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAYLOAD) |-> (q.remain != '0));

    assert_crc_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> !crc_error);

    assert_evt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_frame_start, evt_frame_end, evt_line_start, evt_line_end}));

    assert_evt_with_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_frame_start || evt_frame_end || evt_line_start || evt_line_end) |-> sp_valid);

    assert_short_event_with_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> hdr_valid);

    assert_short_no_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |=> !pl_valid);

    assert_payload_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> (!hdr_valid && !sp_valid));

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pl_last |-> pl_valid);

    assert_rsvd_with_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_error |-> (hdr_valid && !sp_valid));

endmodule

// File: tb/csi2_pkt_parser_tb.sv
module csi2_pkt_parser_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_sot = 1'b0;
    logic        in_eot = 1'b0;

    logic        hdr_valid, sp_valid, pl_valid, pl_last;
    logic [1:0]  hdr_vc, sp_vc, pl_vc;
    logic [5:0]  hdr_dt, sp_dt, pl_dt;
    logic [15:0] hdr_field, sp_data;
    logic [7:0]  hdr_ecc, pl_byte;
    logic        evt_fs, evt_fe, evt_ls, evt_le;
    logic        crc_error, rsvd_error, trunc_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // monitor counters
    int pl_n = 0, last_n = 0, sp_n = 0, hdr_n = 0;
    int fs_n = 0, fe_n = 0, ls_n = 0, le_n = 0;
    int crc_n = 0, rsvd_n = 0, trunc_n = 0;
    logic [7:0]  pl_buf [256];
    logic [1:0]  pl_vc_l;
    logic [5:0]  pl_dt_l;
    logic [15:0] sp_data_l;
    logic [5:0]  sp_dt_l;
    logic [1:0]  sp_vc_l;

    logic [7:0] pay [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    csi2_pkt_parser u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_sot(in_sot), .in_eot(in_eot),
        .hdr_valid(hdr_valid), .hdr_vc(hdr_vc), .hdr_dt(hdr_dt),
        .hdr_field(hdr_field), .hdr_ecc(hdr_ecc),
        .sp_valid(sp_valid), .sp_vc(sp_vc), .sp_dt(sp_dt), .sp_data(sp_data),
        .evt_frame_start(evt_fs), .evt_frame_end(evt_fe),
        .evt_line_start(evt_ls), .evt_line_end(evt_le),
        .pl_valid(pl_valid), .pl_byte(pl_byte), .pl_vc(pl_vc), .pl_dt(pl_dt),
        .pl_last(pl_last),
        .crc_error(crc_error), .rsvd_error(rsvd_error), .trunc_error(trunc_error)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pl_valid) begin
                pl_buf[pl_n % 256] = pl_byte;
                pl_vc_l = pl_vc;
                pl_dt_l = pl_dt;
                pl_n++;
                if (pl_last) last_n++;
            end
            if (sp_valid) begin
                sp_n++;
                sp_data_l = sp_data;
                sp_dt_l   = sp_dt;
                sp_vc_l   = sp_vc;
            end
            if (hdr_valid)   hdr_n++;
            if (evt_fs)      fs_n++;
            if (evt_fe)      fe_n++;
            if (evt_ls)      ls_n++;
            if (evt_le)      le_n++;
            if (crc_error)   crc_n++;
            if (rsvd_error)  rsvd_n++;
            if (trunc_error) trunc_n++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        in_valid = v; in_byte = b; in_sot = s; in_eot = e;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sot = 1'b0; in_eot = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ pay[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return c;
    endfunction

    task automatic send_hdr(input logic [1:0] vc, input logic [5:0] dt,
                            input logic [15:0] fld, input logic [7:0] ecc);
        step(1'b1, {vc, dt}, 1'b1, 1'b0);
        step(1'b1, fld[7:0], 1'b0, 1'b0);
        step(1'b1, fld[15:8], 1'b0, 1'b0);
        step(1'b1, ecc, 1'b0, 1'b0);
    endtask

    task automatic test_reset();
        chk("R10", "hdr_valid after reset", int'(hdr_valid), 0);
        chk("R10", "pl_valid after reset", int'(pl_valid), 0);
        chk("R10", "sp_valid after reset", int'(sp_valid), 0);
        chk("R10", "error flags after reset", int'({crc_error, rsvd_error, trunc_error}), 0);
    endtask

    task automatic test_idle_bytes();
        int h0 = hdr_n, p0 = pl_n, s0 = sp_n, t0 = trunc_n;
        step(1'b1, 8'h1E, 1'b0, 1'b0);
        step(1'b1, 8'h04, 1'b0, 1'b0);
        step(1'b1, 8'h00, 1'b0, 1'b0);
        step(1'b1, 8'h55, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R1", "headers from unframed bytes", hdr_n - h0, 0);
        chk("R1", "payload from unframed bytes", pl_n - p0, 0);
        chk("R1", "short events from unframed bytes", sp_n - s0, 0);
        chk("R9", "trunc on idle eot", trunc_n - t0, 0);
    endtask

    task automatic test_frame_start();
        int s0 = sp_n, f0 = fs_n, p0 = pl_n, t0 = trunc_n, h0 = hdr_n;
        send_hdr(2'd1, 6'h00, 16'h1234, 8'h3C);
        chk("R2", "hdr_valid one cycle after 4th byte", int'(hdr_valid), 1);
        chk("R2", "hdr_vc", int'(hdr_vc), 1);
        chk("R2", "hdr_dt", int'(hdr_dt), 0);
        chk("R2", "hdr_field low byte first", int'(hdr_field), 'h1234);
        chk("R2", "hdr_ecc", int'(hdr_ecc), 'h3C);
        chk("R3", "sp_valid with header", int'(sp_valid), 1);
        // trailing bytes inside the burst must be dropped
        step(1'b1, 8'h10, 1'b0, 1'b0);
        step(1'b1, 8'h03, 1'b0, 1'b0);
        step(1'b1, 8'h00, 1'b0, 1'b0);
        step(1'b1, 8'h99, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R3", "short event count", sp_n - s0, 1);
        chk("R3", "sp_data", int'(sp_data_l), 'h1234);
        chk("R3", "sp_vc", int'(sp_vc_l), 1);
        chk("R4", "frame start strobe", fs_n - f0, 1);
        chk("R1", "no extra header after short", hdr_n - h0, 1);
        chk("R3", "no payload from short packet", pl_n - p0, 0);
        chk("R9", "no trunc after complete short", trunc_n - t0, 0);
    endtask

    task automatic test_other_shorts();
        int fe0 = fe_n, ls0 = ls_n, le0 = le_n, fs0 = fs_n, s0 = sp_n;
        send_hdr(2'd0, 6'h01, 16'h0007, 8'h11);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        send_hdr(2'd3, 6'h02, 16'h0020, 8'h22);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        send_hdr(2'd2, 6'h03, 16'h0021, 8'h33);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        send_hdr(2'd2, 6'h05, 16'hBEEF, 8'h44);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        send_hdr(2'd1, 6'h0A, 16'hCAFE, 8'h55);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R4", "frame end strobe", fe_n - fe0, 1);
        chk("R4", "line start strobe", ls_n - ls0, 1);
        chk("R4", "line end strobe", le_n - le0, 1);
        chk("R4", "no frame start for other codes", fs_n - fs0, 0);
        chk("R3", "all five short events", sp_n - s0, 5);
        chk("R3", "generic short data", int'(sp_data_l), 'hCAFE);
        chk("R3", "generic short type", int'(sp_dt_l), 'h0A);
    endtask

    task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int wc,
                             input bit good, input int extra, input bit check_first);
        logic [15:0] c;
        c = ref_crc(wc);
        if (!good) c = c ^ 16'h0100;
        send_hdr(vc, dt, 16'(wc), 8'h5A);
        for (int i = 0; i < wc; i++) begin
            step(1'b1, pay[i], 1'b0, 1'b0);
            if (check_first && i == 0) begin
                chk("R5", "first payload one cycle after accept", int'(pl_valid), 1);
                chk("R5", "first payload byte", int'(pl_byte), int'(pay[0]));
            end
        end
        step(1'b1, c[7:0], 1'b0, 1'b0);
        step(1'b1, c[15:8], 1'b0, 1'b0);
        for (int i = 0; i < extra; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
    endtask

    task automatic test_long_good();
        int p0 = pl_n, l0 = last_n, c0 = crc_n, t0 = trunc_n, mism = 0;
        for (int i = 0; i < 10; i++) pay[i] = 8'((i * 37 + 5) ^ 8'h6B);
        send_long(2'd2, 6'h2A, 10, 1'b1, 3, 1'b1);
        chk("R5", "payload byte count", pl_n - p0, 10);
        for (int i = 0; i < 10; i++)
            if (pl_buf[(p0 + i) % 256] != pay[i]) mism++;
        chk("R5", "payload byte mismatches", mism, 0);
        chk("R5", "payload vc tag", int'(pl_vc_l), 2);
        chk("R5", "payload dt tag", int'(pl_dt_l), 'h2A);
        chk("R5", "one pl_last", last_n - l0, 1);
        chk("R7", "no crc_error on good footer", crc_n - c0, 0);
        chk("R9", "no trunc after full long packet", trunc_n - t0, 0);
    endtask

    task automatic test_long_bad();
        int c0 = crc_n, p0 = pl_n;
        for (int i = 0; i < 6; i++) pay[i] = 8'(8'hF0 - i * 3);
        send_long(2'd0, 6'h1E, 6, 1'b0, 0, 1'b0);
        chk("R7", "single-cycle crc_error on bad footer", crc_n - c0, 1);
        chk("R5", "payload count with bad footer", pl_n - p0, 6);
    endtask

    task automatic test_crc_timing();
        logic [15:0] c;
        int c0 = crc_n;
        pay[0] = 8'h01; pay[1] = 8'h02;
        c = ref_crc(2) ^ 16'h8000;
        send_hdr(2'd1, 6'h24, 16'd2, 8'h00);
        step(1'b1, pay[0], 1'b0, 1'b0);
        step(1'b1, pay[1], 1'b0, 1'b0);
        step(1'b1, c[7:0], 1'b0, 1'b0);
        chk("R7", "crc_error low after first footer byte", int'(crc_error), 0);
        step(1'b1, c[15:8], 1'b0, 1'b0);
        chk("R7", "crc_error high after second footer byte", int'(crc_error), 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R7", "crc_error pulse width", crc_n - c0, 1);
    endtask

    task automatic test_empty_long();
        int p0 = pl_n, c0 = crc_n, s0 = sp_n;
        send_long(2'd3, 6'h12, 0, 1'b1, 2, 1'b0);
        chk("R6", "no payload for zero count", pl_n - p0, 0);
        chk("R6", "empty footer equals seed", crc_n - c0, 0);
        chk("R6", "footer bytes not seen as short", sp_n - s0, 0);
    endtask

    task automatic test_reserved();
        int r0 = rsvd_n, p0 = pl_n, s0 = sp_n, h0 = hdr_n;
        send_hdr(2'd1, 6'h3A, 16'h0004, 8'h77);
        chk("R8", "rsvd_error with header", int'(rsvd_error), 1);
        for (int i = 0; i < 6; i++) step(1'b1, 8'(i + 1), 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R8", "one reserved error", rsvd_n - r0, 1);
        chk("R8", "no payload after reserved", pl_n - p0, 0);
        chk("R8", "no short event after reserved", sp_n - s0, 0);
        chk("R8", "only one header", hdr_n - h0, 1);
    endtask

    task automatic test_truncation();
        int t0 = trunc_n, p0 = pl_n, c0 = crc_n;
        for (int i = 0; i < 8; i++) pay[i] = 8'(i + 8'h40);
        send_hdr(2'd0, 6'h2B, 16'd8, 8'h01);
        for (int i = 0; i < 4; i++) step(1'b1, pay[i], 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R9", "trunc_error one cycle after eot", int'(trunc_error), 1);
        idle(2);
        chk("R9", "payload before truncation", pl_n - p0, 4);
        chk("R9", "no crc check on truncated", crc_n - c0, 0);
        // header cut short
        step(1'b1, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h01, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        // footer cut short
        send_hdr(2'd0, 6'h2B, 16'd1, 8'h01);
        step(1'b1, 8'h99, 1'b0, 1'b0);
        step(1'b1, 8'h12, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R9", "three truncations", trunc_n - t0, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        test_reset();
        test_idle_bytes();
        test_frame_start();
        test_other_shorts();
        test_long_good();
        test_long_bad();
        test_crc_timing();
        test_empty_long();
        test_reserved();
        test_truncation();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule